// File: doc/BRIEF.md
# Secure Protection-Controller Configuration Register Bank

This block is the secure-side register bank that configures a set of peripheral protection controllers. It sits in a 4 KB register window and is reached over a simple word-addressed bus with byte-lane enables. For every protection controller it keeps two port masks. The non-secure mask is also driven out as one non-secure level per port. The secure-privilege mask is stored and read back. The block also gathers the interrupt levels from the protection controllers and the memory-protection controllers into status words. It keeps an interrupt enable word and accepts write-one-to-clear commands. It drives a response-configuration bit and a two-bit configuration field, and it answers a fixed sequence of identification bytes.

There are ten protection controllers. Controllers 0 and 1 sit on the internal peripheral bus, and controllers 2 to 5 sit on the peripheral expansion bus. Controllers 6 to 9 sit on the system-bus expansion. Each register group takes a 16-byte block, and the controller within the group is picked by byte-address bits [3:2]. The bank has no state machine. Every access completes in one cycle. Read data comes out of a register one cycle after the request.

Top module: `secctl_s_regbank`

## Requirements
- R1: After reset, every mask, the enable word, the interrupt status, the bridge enable and both configuration registers are zero. All non-secure port outputs are low.
- R2: A full write to offset 0x10 keeps only bit 0, and `resp_cfg_o` shows it. A full write to offset 0x14 keeps only bits [1:0], and `nsc_cfg_o` shows them. Both registers read back.
- R3: A write is ignored unless `be_i` is 4'hF. A read returns the register word with every lane whose `be_i` bit is clear forced to zero.
- R4: Non-secure masks sit at 0x60–0x6C (controllers 6–9), 0x70–0x74 (controllers 0–1) and 0x80–0x8C (controllers 2–5), indexed by byte-address bits [3:2]. A write keeps only the low port-count bits, and each stored bit drives that port's non-secure output. The port counts are 3, 1 and 16 for controllers 0, 1 and 2–9.
- R5: Secure-privilege masks sit at 0xA0–0xAC, 0xB0–0xB4 and 0xC0–0xCC with the same indexing and truncation. They read back and never change a non-secure output.
- R6: Status word 0x20 follows the level inputs one cycle later. Input `ppc_irq_i[i]` lands in bit i for i=0..1, in bit i+2 for i=2..5 and in bit i+14 for i=6..9. `ppc_irq_clr_o[i]` equals that status bit.
- R7: A write to 0x28 keeps only the bits under mask 0x00F000F3. `ppc_irq_en_o[i]` equals the enable bit at the same position used in R6.
- R8: Writing ones to 0x24 clears the matching status bits for one cycle, and the clear wins over a high input in that cycle. From the next cycle the bit follows its input again.
- R9: Word 0x1C is read-only. Internal memory-protection input n appears at bit n, and expansion input n appears at bit n+16.
- R10: 0x40, 0x50 and 0x90 read zero. 0x48 keeps only bits [31:16].
- R11: Offsets 0xFD0 to 0xFFC read, in address order, the bytes 04 00 00 00 52 B8 0B 00 0D F0 05 B1 in bits [7:0].
- R12: Writes to read-only or unmapped offsets change nothing. Reads of 0x24, 0x44 or unmapped offsets return zero.
- R13: `rdata_o` carries the read result in the cycle after the request and is zero in any cycle that follows no read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 1 | Access request |
| wr_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 10 | Word address (byte offset bits [11:2]) |
| be_i | input | 4 | Byte-lane enables |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| ppc_irq_i | input | 10 | Protection-controller interrupt levels |
| mpc_irq_i | input | N_MPC | Internal memory-protection interrupt levels |
| mpc_exp_irq_i | input | N_MPC_EXP | Expansion memory-protection interrupt levels |
| ppc_irq_en_o | output | 10 | Per-controller interrupt enable |
| ppc_irq_clr_o | output | 10 | Per-controller status/clear level |
| resp_cfg_o | output | 1 | Response-configuration bit |
| nsc_cfg_o | output | 2 | Two-bit configuration field |
| ns_apb_int0_o | output | P_APB_INT0 | Non-secure levels, controller 0 |
| ns_apb_int1_o | output | P_APB_INT1 | Non-secure levels, controller 1 |
| ns_apb_exp_o | output | 4*P_EXP | Non-secure levels, controllers 2–5 |
| ns_ahb_exp_o | output | 4*P_EXP | Non-secure levels, controllers 6–9 |

## Verification
Two functions can meet in one cycle: a software clear of a status bit and that bit's interrupt level being high. The bench holds every interrupt input high, then issues a clear for a single controller. On the edge that takes the write, `ppc_irq_clr_o` must drop only that controller's bit. One cycle later it must be high again while all other bits stay high. The bench also sweeps all 1024 input patterns and checks the status word against the bit mapping it works out itself.

// File: rtl/secctl_pkg.sv
package secctl_pkg;

    localparam int NUM_PPC = 10;

    // register group codes: byte offset bits [11:4]
    typedef enum logic [7:0] {
        GRP_NS_AHBX = 8'h06,
        GRP_NS_APBI = 8'h07,
        GRP_NS_APBX = 8'h08,
        GRP_SP_AHBX = 8'h0A,
        GRP_SP_APBI = 8'h0B,
        GRP_SP_APBX = 8'h0C
    } grp_e;

    // word addresses of single registers
    localparam logic [9:0] W_RESP     = 10'h004;
    localparam logic [9:0] W_NSC      = 10'h005;
    localparam logic [9:0] W_MPC      = 10'h007;
    localparam logic [9:0] W_PSTAT    = 10'h008;
    localparam logic [9:0] W_PCLR     = 10'h009;
    localparam logic [9:0] W_PEN      = 10'h00A;
    localparam logic [9:0] W_BRG_EN   = 10'h012;
    localparam logic [9:0] W_ID_FIRST = 10'h3F4;

    // position of controller i in the status and enable words
    function automatic int ppc_bit_pos(int i);
        if (i < 2)      return i;
        else if (i < 6) return i + 2;
        else            return i + 14;
    endfunction

    function automatic logic [7:0] id_byte(int k);
        case (k)
            0:       return 8'h04;
            4:       return 8'h52;
            5:       return 8'hB8;
            6:       return 8'h0B;
            8:       return 8'h0D;
            9:       return 8'hF0;
            10:      return 8'h05;
            11:      return 8'hB1;
            default: return 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/secctl_ppc_slot.sv
module secctl_ppc_slot #(
    parameter int PORTS = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we_ns,
    input  logic             we_sp,
    input  logic [PORTS-1:0] wdata_i,
    output logic [31:0]      ns_word_o,
    output logic [31:0]      sp_word_o
);

    logic [PORTS-1:0] ns_q;
    logic [PORTS-1:0] sp_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ns_q <= '0;
            sp_q <= '0;
        end else begin
            if (we_ns) ns_q <= wdata_i;
            if (we_sp) sp_q <= wdata_i;
        end
    end

    assign ns_word_o = 32'(ns_q);
    assign sp_word_o = 32'(sp_q);

    p_ns_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
        we_ns |=> ns_word_o == 32'($past(wdata_i)));

    p_sp_keeps_ns_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (we_sp && !we_ns) |=> $stable(ns_word_o));

endmodule

// File: rtl/secctl_irq_bank.sv
module secctl_irq_bank
    import secctl_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_PPC-1:0] irq_i,
    input  logic               en_we,
    input  logic               clr_we,
    input  logic [NUM_PPC-1:0] wsel_i,
    output logic [NUM_PPC-1:0] en_o,
    output logic [NUM_PPC-1:0] clr_o,
    output logic [31:0]        en_word_o,
    output logic [31:0]        stat_word_o
);

    logic [NUM_PPC-1:0] en_q;
    logic [NUM_PPC-1:0] stat_q;
    logic [NUM_PPC-1:0] kill;

    assign kill = clr_we ? wsel_i : '0;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= '0;
            stat_q <= '0;
        end else begin
            stat_q <= irq_i & ~kill;
            if (en_we) en_q <= wsel_i;
        end
    end

    always_comb begin
        en_word_o   = '0;
        stat_word_o = '0;
        for (int i = 0; i < NUM_PPC; i++) begin
            en_word_o[ppc_bit_pos(i)]   = en_q[i];
            stat_word_o[ppc_bit_pos(i)] = stat_q[i];
        end
    end

    assign en_o  = en_q;
    assign clr_o = stat_q;

    for (genvar g = 0; g < NUM_PPC; g++) begin : g_chk
        p_clear_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_we && wsel_i[g]) |=> !clr_o[g]);
        p_status_follows_r6: assert property (@(posedge clk) disable iff (!rst_n)
            !(clr_we && wsel_i[g]) |=> clr_o[g] == $past(irq_i[g]));
        p_enable_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
            !en_we |=> $stable(en_o[g]));
    end

endmodule

// File: rtl/secctl_s_regbank.sv
module secctl_s_regbank
    import secctl_pkg::*;
#(
    parameter int P_APB_INT0 = 3,
    parameter int P_APB_INT1 = 1,
    parameter int P_EXP      = 16,
    parameter int N_MPC      = 2,
    parameter int N_MPC_EXP  = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_i,
    input  logic                   wr_i,
    input  logic [9:0]             addr_i,
    input  logic [3:0]             be_i,
    input  logic [31:0]            wdata_i,
    output logic [31:0]            rdata_o,
    input  logic [NUM_PPC-1:0]     ppc_irq_i,
    input  logic [N_MPC-1:0]       mpc_irq_i,
    input  logic [N_MPC_EXP-1:0]   mpc_exp_irq_i,
    output logic [NUM_PPC-1:0]     ppc_irq_en_o,
    output logic [NUM_PPC-1:0]     ppc_irq_clr_o,
    output logic                   resp_cfg_o,
    output logic [1:0]             nsc_cfg_o,
    output logic [P_APB_INT0-1:0]  ns_apb_int0_o,
    output logic [P_APB_INT1-1:0]  ns_apb_int1_o,
    output logic [4*P_EXP-1:0]     ns_apb_exp_o,
    output logic [4*P_EXP-1:0]     ns_ahb_exp_o
);

    localparam int N_EXP_PPC = 4;

    logic        wr_ok;
    logic        rd_req;
    logic        slot_hit;
    logic        slot_sp;
    logic [3:0]  slot_id;
    logic [7:0]  grp;
    logic [1:0]  idx;
    logic [31:0] rval;
    logic [31:0] lane_mask;
    logic [31:0] mpc_word;
    logic [31:0] rdata_q;
    logic        resp_q;
    logic [1:0]  nsc_q;
    logic [15:0] brg_q;

    logic [NUM_PPC-1:0] we_ns;
    logic [NUM_PPC-1:0] we_sp;
    logic [NUM_PPC-1:0] wsel;
    logic [31:0]        ns_word [NUM_PPC];
    logic [31:0]        sp_word [NUM_PPC];
    logic [31:0]        en_word;
    logic [31:0]        stat_word;

    assign wr_ok  = req_i && wr_i && (be_i == 4'hF);
    assign rd_req = req_i && !wr_i;
    assign grp    = addr_i[9:2];
    assign idx    = addr_i[1:0];

    // group/slot decode
    always_comb begin
        slot_hit = 1'b0;
        slot_sp  = 1'b0;
        slot_id  = '0;
        case (grp_e'(grp))
            GRP_NS_AHBX: begin slot_hit = 1'b1; slot_id = 4'd6 + 4'(idx); end
            GRP_NS_APBI: begin slot_hit = !idx[1]; slot_id = 4'(idx); end
            GRP_NS_APBX: begin slot_hit = 1'b1; slot_id = 4'd2 + 4'(idx); end
            GRP_SP_AHBX: begin slot_hit = 1'b1; slot_sp = 1'b1; slot_id = 4'd6 + 4'(idx); end
            GRP_SP_APBI: begin slot_hit = !idx[1]; slot_sp = 1'b1; slot_id = 4'(idx); end
            GRP_SP_APBX: begin slot_hit = 1'b1; slot_sp = 1'b1; slot_id = 4'd2 + 4'(idx); end
            default: ;
        endcase
    end

    for (genvar g = 0; g < NUM_PPC; g++) begin : g_slot
        localparam int PN = (g == 0) ? P_APB_INT0 : (g == 1) ? P_APB_INT1 : P_EXP;
        assign we_ns[g] = wr_ok && slot_hit && !slot_sp && (slot_id == 4'(g));
        assign we_sp[g] = wr_ok && slot_hit &&  slot_sp && (slot_id == 4'(g));
        assign wsel[g]  = wdata_i[ppc_bit_pos(g)];
        secctl_ppc_slot #(.PORTS(PN)) u_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .we_ns     (we_ns[g]),
            .we_sp     (we_sp[g]),
            .wdata_i   (wdata_i[PN-1:0]),
            .ns_word_o (ns_word[g]),
            .sp_word_o (sp_word[g])
        );
    end

    assign ns_apb_int0_o = ns_word[0][P_APB_INT0-1:0];
    assign ns_apb_int1_o = ns_word[1][P_APB_INT1-1:0];
    for (genvar k = 0; k < N_EXP_PPC; k++) begin : g_nsout
        assign ns_apb_exp_o[k*P_EXP +: P_EXP] = ns_word[2+k][P_EXP-1:0];
        assign ns_ahb_exp_o[k*P_EXP +: P_EXP] = ns_word[6+k][P_EXP-1:0];
    end

    secctl_irq_bank u_irq (
        .clk         (clk),
        .rst_n       (rst_n),
        .irq_i       (ppc_irq_i),
        .en_we       (wr_ok && addr_i == W_PEN),
        .clr_we      (wr_ok && addr_i == W_PCLR),
        .wsel_i      (wsel),
        .en_o        (ppc_irq_en_o),
        .clr_o       (ppc_irq_clr_o),
        .en_word_o   (en_word),
        .stat_word_o (stat_word)
    );

    // global configuration and bridge enable
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resp_q <= 1'b0;
            nsc_q  <= 2'b00;
            brg_q  <= '0;
        end else if (wr_ok) begin
            if (addr_i == W_RESP)   resp_q <= wdata_i[0];
            if (addr_i == W_NSC)    nsc_q  <= wdata_i[1:0];
            if (addr_i == W_BRG_EN) brg_q  <= wdata_i[31:16];
        end
    end

    assign resp_cfg_o = resp_q;
    assign nsc_cfg_o  = nsc_q;
    assign mpc_word   = 32'(mpc_irq_i) | (32'(mpc_exp_irq_i) << 16);

    // read mux
    always_comb begin
        rval = '0;
        if (slot_hit) begin
            rval = slot_sp ? sp_word[slot_id] : ns_word[slot_id];
        end else if (addr_i >= W_ID_FIRST) begin
            rval = {24'b0, id_byte(int'(addr_i - W_ID_FIRST))};
        end else begin
            case (addr_i)
                W_RESP:   rval = {31'b0, resp_q};
                W_NSC:    rval = {30'b0, nsc_q};
                W_MPC:    rval = mpc_word;
                W_PSTAT:  rval = stat_word;
                W_PEN:    rval = en_word;
                W_BRG_EN: rval = {brg_q, 16'b0};
                default:  rval = '0;
            endcase
        end
    end

    assign lane_mask = {{8{be_i[3]}}, {8{be_i[2]}}, {8{be_i[1]}}, {8{be_i[0]}}};

    always_ff @(posedge clk) begin
        if (!rst_n) rdata_q <= '0;
        else        rdata_q <= rd_req ? (rval & lane_mask) : '0;
    end

    assign rdata_o = rdata_q;

    p_narrow_write_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && wr_i && be_i != 4'hF) |=>
            ($stable(resp_cfg_o) && $stable(nsc_cfg_o) && $stable(ns_apb_exp_o)
             && $stable(ns_ahb_exp_o) && $stable(ppc_irq_en_o)));

    p_resp_cfg_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ok && addr_i == W_RESP) |=> resp_cfg_o == $past(wdata_i[0]));

    p_rdata_idle_zero_r13: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_i && !wr_i) |=> rdata_o == '0);

    p_clear_reg_reads_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && !wr_i && addr_i == W_PCLR) |=> rdata_o == '0);

endmodule

// File: tb/tb_secctl_s_regbank.sv
`timescale 1ns/1ps
module tb_secctl_s_regbank;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic        wr = 1'b0;
    logic [9:0]  addr = '0;
    logic [3:0]  be = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [9:0]  irq = '0;
    logic [1:0]  mpc = '0;
    logic [3:0]  mpcx = '0;
    logic [9:0]  en_o, clr_o;
    logic        resp;
    logic [1:0]  nsc;
    logic [2:0]  ns0;
    logic [0:0]  ns1;
    logic [63:0] nsapb, nsahb;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;
    logic [31:0] ns_m [10];
    logic [31:0] rd;

    always #4 clk = ~clk;

    secctl_s_regbank dut (
        .clk(clk), .rst_n(rst_n), .req_i(req), .wr_i(wr), .addr_i(addr),
        .be_i(be), .wdata_i(wdata), .rdata_o(rdata), .ppc_irq_i(irq),
        .mpc_irq_i(mpc), .mpc_exp_irq_i(mpcx), .ppc_irq_en_o(en_o),
        .ppc_irq_clr_o(clr_o), .resp_cfg_o(resp), .nsc_cfg_o(nsc),
        .ns_apb_int0_o(ns0), .ns_apb_int1_o(ns1),
        .ns_apb_exp_o(nsapb), .ns_ahb_exp_o(nsahb)
    );

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    task automatic bwrite(int off, logic [31:0] d, logic [3:0] lanes = 4'hF);
        @(negedge clk);
        req = 1'b1; wr = 1'b1; addr = 10'(off >> 2); be = lanes; wdata = d;
        @(negedge clk);
        req = 1'b0; wr = 1'b0;
    endtask

    task automatic bread(int off, output logic [31:0] d, input logic [3:0] lanes = 4'hF);
        @(negedge clk);
        req = 1'b1; wr = 1'b0; addr = 10'(off >> 2); be = lanes;
        @(negedge clk);
        req = 1'b0;
        d = rdata;
    endtask

    function automatic int bitpos(int i);
        return (i < 2) ? i : (i < 6) ? i + 2 : i + 14;
    endfunction

    function automatic int pcount(int s);
        return (s == 0) ? 3 : (s == 1) ? 1 : 16;
    endfunction

    function automatic logic [31:0] pmask(int s);
        return 32'((64'd1 << pcount(s)) - 1);
    endfunction

    function automatic int slot_off(int s, bit sp);
        if (s < 2)      return (sp ? 'hB0 : 'h70) + 4 * s;
        else if (s < 6) return (sp ? 'hC0 : 'h80) + 4 * (s - 2);
        else            return (sp ? 'hA0 : 'h60) + 4 * (s - 6);
    endfunction

    function automatic logic [31:0] get_ns(int s);
        if (s == 0)      return 32'(ns0);
        else if (s == 1) return 32'(ns1);
        else if (s < 6)  return 32'(nsapb[(s-2)*16 +: 16]);
        else             return 32'(nsahb[(s-6)*16 +: 16]);
    endfunction

    function automatic logic [31:0] expand(logic [9:0] v);
        logic [31:0] w = '0;
        for (int i = 0; i < 10; i++) w[bitpos(i)] = v[i];
        return w;
    endfunction

    task automatic check_all_ns(string tag);
        for (int s = 0; s < 10; s++) check(tag, get_ns(s), ns_m[s]);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        for (int s = 0; s < 10; s++) ns_m[s] = '0;
        check_all_ns("R1 ns out");
        check("R1 resp", 32'(resp), 0);
        check("R1 nsc", 32'(nsc), 0);
        check("R1 en", 32'(en_o), 0);
        for (int s = 0; s < 10; s++) begin
            bread(slot_off(s, 0), rd); check("R1 ns mask", rd, 0);
            bread(slot_off(s, 1), rd); check("R1 sp mask", rd, 0);
        end
        bread('h28, rd); check("R1 enable", rd, 0);
        bread('h48, rd); check("R1 bridge", rd, 0);

        // R4 non-secure masks
        for (int s = 0; s < 10; s++) begin
            logic [31:0] pats [3];
            pats[0] = 32'hFFFF_FFFF;
            pats[1] = 32'h0000_0000;
            pats[2] = 32'hA5C3_5A3C ^ (32'h1111 * s);
            for (int p = 0; p < 3; p++) begin
                bwrite(slot_off(s, 0), pats[p]);
                ns_m[s] = pats[p] & pmask(s);
                check_all_ns("R4 ns outputs");
                bread(slot_off(s, 0), rd);
                check("R4 ns readback", rd, ns_m[s]);
            end
        end

        // R5 secure-privilege masks
        for (int s = 0; s < 10; s++) begin
            bwrite(slot_off(s, 1), 32'h6E1F_93B7 + s);
            bread(slot_off(s, 1), rd);
            check("R5 sp readback", rd, (32'h6E1F_93B7 + s) & pmask(s));
            check_all_ns("R5 ns untouched");
        end

        // R2 configuration outputs
        bwrite('h10, 32'hFFFF_FFFF);
        check("R2 resp out", 32'(resp), 1);
        bread('h10, rd); check("R2 resp read", rd, 1);
        bwrite('h14, 32'hFFFF_FFFE);
        check("R2 nsc out", 32'(nsc), 2);
        bread('h14, rd); check("R2 nsc read", rd, 2);
        bwrite('h10, 32'h0000_0002);
        check("R2 resp clear", 32'(resp), 0);

        // R3 narrow writes ignored, lane reads
        bwrite('h48, 32'h9ABC_0000);
        for (int b = 0; b < 15; b++) begin
            bwrite('h48, 32'hFFFF_FFFF, 4'(b));
            bwrite('h10, 32'h1, 4'(b));
            check("R3 narrow write resp", 32'(resp), 0);
        end
        bread('h48, rd); check("R3 narrow write bridge", rd, 32'h9ABC_0000);
        for (int b = 0; b < 16; b++) begin
            logic [31:0] lm;
            lm = {{8{b[3]}}, {8{b[2]}}, {8{b[1]}}, {8{b[0]}}};
            bread('h48, rd, 4'(b));
            check("R3 lane read", rd, 32'h9ABC_0000 & lm);
        end

        // R10 fixed reads and bridge mask
        bwrite('h48, 32'hFFFF_FFFF);
        bread('h48, rd); check("R10 bridge mask", rd, 32'hFFFF_0000);
        bread('h40, rd); check("R10 bridge status", rd, 0);
        bread('h50, rd); check("R10 0x50", rd, 0);
        bread('h90, rd); check("R10 0x90", rd, 0);

        // R6 status mapping, exhaustive
        for (int p = 0; p < 1024; p++) begin
            @(negedge clk);
            irq = 10'(p);
            @(negedge clk);
            check("R6 clr out", 32'(clr_o), 32'(p));
            bread('h20, rd);
            check("R6 status word", rd, expand(10'(p)));
        end

        // R7 enable
        bwrite('h28, 32'hFFFF_FFFF);
        bread('h28, rd); check("R7 enable mask", rd, 32'h00F0_00F3);
        check("R7 en out", 32'(en_o), 32'h3FF);
        for (int i = 0; i < 10; i++) begin
            bwrite('h28, 32'h1 << bitpos(i));
            check("R7 single enable", 32'(en_o), 32'h1 << i);
        end

        // R8 clear versus a high level in the same cycle
        @(negedge clk); irq = 10'h3FF;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            check("R8 status set", 32'(clr_o), 32'h3FF);
            bwrite('h24, 32'h1 << bitpos(i));
            check("R8 clear wins", 32'(clr_o), 32'h3FF & ~(32'h1 << i));
            @(negedge clk);
            check("R8 follows again", 32'(clr_o), 32'h3FF);
        end
        @(negedge clk); irq = '0;

        // R9 memory-protection status
        for (int m = 0; m < 64; m++) begin
            @(negedge clk);
            mpc = m[1:0]; mpcx = m[5:2];
            bread('h1C, rd);
            check("R9 mpc status", rd, 32'(m[1:0]) | (32'(m[5:2]) << 16));
        end
        bwrite('h1C, 32'h0);
        bread('h1C, rd); check("R9 read-only", rd, 32'h000F_0003);

        // R11 identification bytes
        begin
            logic [7:0] idv [12] = '{8'h04, 8'h00, 8'h00, 8'h00, 8'h52, 8'hB8,
                                     8'h0B, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};
            for (int k = 0; k < 12; k++) begin
                bwrite('hFD0 + 4 * k, 32'hFFFF_FFFF);
                bread('hFD0 + 4 * k, rd);
                check("R11 id byte", rd, 32'(idv[k]));
            end
        end

        // R12 write-only and unmapped offsets
        bwrite('h30, 32'hFFFF_FFFF);
        bread('h30, rd); check("R12 unmapped", rd, 0);
        bread('h24, rd); check("R12 clear reg read", rd, 0);
        bwrite('h44, 32'hFFFF_FFFF);
        bread('h44, rd); check("R12 bridge clear read", rd, 0);
        bwrite('h78, 32'hFFFF_FFFF);
        check_all_ns("R12 gap in internal group");
        bwrite('h40, 32'hFFFF_FFFF);
        bread('h48, rd); check("R12 ro write no effect", rd, 32'hFFFF_0000);

        // R13 read timing
        bread('h14, rd); check("R13 data cycle", rd, 2);
        @(negedge clk); check("R13 idle zero", rdata, 0);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule